// File: doc/BRIEF.md
# Out-of-Order Instruction Window with Tag Wakeup and In-Order Retirement

This block holds a small circular window of in-flight instructions for an out-of-order core. Each cycle the decode side may insert one instruction. The block gives it a tag that follows program order, and it looks both source registers up in a rename map. A source that has no in-flight producer takes its value from the committed register file. A source whose producer already has a result takes that result. Any other source holds the producer's tag and waits.

Execution units send back a tag with its result. Every waiting operand that carries the matching tag captures the value at once. Each cycle the oldest entry whose operands are both present goes out on the dispatch port, and it is never sent a second time. Finished entries retire from the head in program order and write the committed register file. If the head entry finished with an exception, the whole window is discarded instead and the rename map is invalidated.

Top module: `rob_window`

## Requirements
- R1: After reset the window is empty: `disp_valid`, `cmt_valid` and `flush` are low, `alloc_stall` is low and `alloc_tag` is 0.
- R2: Accepted allocations receive tags 0,1,…,DEPTH-1 and then wrap. When DEPTH entries are occupied, `alloc_stall` is high and a request that cycle is ignored. A commit in the same cycle does not make room for that request.
- R3: At allocation, each source is marked present with a value. The value is the committed register when the rename map has no valid producer for that register. It is the producer's result when the producer has already finished. It is the broadcast result when the producer finishes in that same cycle.
- R4: A waiting source whose tag equals a non-exception completion tag captures `done_data` at that edge. The entry can dispatch from the next cycle.
- R5: An entry is dispatched only when it is occupied, not yet dispatched, and both sources are present. At most one entry is dispatched per cycle, and each entry is dispatched once.
- R6: When several entries are ready, the one nearest the commit point in program order is dispatched first. This choice does not depend on the raw slot index.
- R7: The head entry retires only after it has finished. Retirement follows allocation order, drives `cmt_valid` with its tag, destination and result, and writes the register file when the destination flag is set.
- R8: If the head entry finished with its exception flag set, then in the cycle it reaches retirement `flush` is high, `flush_cause` gives its cause, nothing is written to the register file, and `alloc_stall` is high. From the next cycle the window is empty, and the next tag handed out equals the excepting entry's tag. A completion with the exception flag set wakes no waiting sources.
- R9: After a flush, every rename mapping is invalid, so sources read committed register values.
- R10: A retirement clears a register's rename mapping only if that mapping still names the retiring tag. A younger writer of the same register keeps its mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Decode presents an instruction |
| alloc_op | input | OP_W | Operation code carried to dispatch |
| alloc_src_a | input | REG_W | First source register |
| alloc_src_b | input | REG_W | Second source register |
| alloc_dst_en | input | 1 | Instruction writes a destination |
| alloc_dst | input | REG_W | Destination register |
| alloc_stall | output | 1 | Allocation refused this cycle |
| alloc_tag | output | TAG_W | Tag the next accepted instruction receives |
| disp_valid | output | 1 | An entry is dispatched this cycle |
| disp_tag | output | TAG_W | Tag of the dispatched entry |
| disp_op | output | OP_W | Its operation code |
| disp_a | output | DATA_W | Its first operand value |
| disp_b | output | DATA_W | Its second operand value |
| done_valid | input | 1 | An execution unit finishes an entry |
| done_tag | input | TAG_W | Tag of the finished entry |
| done_data | input | DATA_W | Its result |
| done_exc | input | 1 | The entry raised an exception |
| done_cause | input | CAUSE_W | Exception cause code |
| cmt_valid | output | 1 | Head entry retires normally |
| cmt_tag | output | TAG_W | Tag of the retiring or flushing entry |
| cmt_dst_en | output | 1 | Retiring entry writes a register |
| cmt_dst | output | REG_W | Its destination register |
| cmt_data | output | DATA_W | Its result |
| flush | output | 1 | Head exception discards the window |
| flush_cause | output | CAUSE_W | Cause of that exception |

## Verification
The properties assume that the environment reports completion only for tags that are occupied and have been dispatched, and reports each such tag only once. Without that, the done flags and the wakeup broadcasts could refer to a stale or empty slot. The stimulus keeps to this rule because every completion is issued a few cycles after the bench has seen that tag leave on the dispatch port. The stimulus also never presents an allocation while `alloc_stall` is high, except for one deliberate attempt that checks the request is ignored.

// File: rtl/rob_pkg.sv
package rob_pkg;
    parameter int ROB_DEPTH = 4;     // power of two
    parameter int NUM_ARCH  = 8;
    parameter int DATA_W    = 16;
    parameter int OP_W      = 4;
    parameter int CAUSE_W   = 4;
    localparam int TAG_W = $clog2(ROB_DEPTH);
    localparam int REG_W = $clog2(NUM_ARCH);

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [TAG_W:0]    ptr_t;
    typedef logic [REG_W-1:0]  reg_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef struct packed {
        logic  p;
        data_t v;       // value when p, producer tag in low bits otherwise
    } operand_t;

    typedef struct packed {
        logic               used;
        logic               exec;
        logic               done;
        logic [OP_W-1:0]    op;
        operand_t           a;
        operand_t           b;
        logic               dst_en;
        reg_t               dst;
        data_t              data;
        logic               exc;
        logic [CAUSE_W-1:0] cause;
    } slot_t;

    function automatic logic ptr_full(ptr_t h, ptr_t t);
        return (h[TAG_W-1:0] == t[TAG_W-1:0]) && (h[TAG_W] != t[TAG_W]);
    endfunction
endpackage

// File: rtl/rob_pick.sv
module rob_pick #(
    parameter int N = 4,
    parameter int W = 2
) (
    input  logic [N-1:0] rdy,
    input  logic [W-1:0] base,
    output logic         hit,
    output logic [W-1:0] idx
);
    logic [W-1:0] cand;
    always_comb begin
        hit  = 1'b0;
        idx  = base;
        cand = base;
        for (int k = 0; k < N; k++) begin
            cand = base + W'(k);
            if (!hit && rdy[cand]) begin
                hit = 1'b1;
                idx = cand;
            end
        end
    end
endmodule

// File: rtl/rob_rename.sv
module rob_rename
    import rob_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  reg_t look_a,
    input  reg_t look_b,
    output logic hit_a,
    output tag_t tag_a,
    output logic hit_b,
    output tag_t tag_b,
    input  logic set_en,
    input  reg_t set_reg,
    input  tag_t set_tag,
    input  logic rel_en,
    input  reg_t rel_reg,
    input  tag_t rel_tag,
    input  logic inv_all
);
    logic [NUM_ARCH-1:0] map_v;
    tag_t                map_t [NUM_ARCH];

    assign hit_a = map_v[look_a];
    assign tag_a = map_t[look_a];
    assign hit_b = map_v[look_b];
    assign tag_b = map_t[look_b];

    always_ff @(posedge clk) begin
        if (rst || inv_all) begin
            map_v <= '0;
        end else begin
            for (int r = 0; r < NUM_ARCH; r++) begin
                if (set_en && set_reg == reg_t'(r)) begin
                    map_v[r] <= 1'b1;
                    map_t[r] <= set_tag;
                end else if (rel_en && rel_reg == reg_t'(r) && map_t[r] == rel_tag) begin
                    map_v[r] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/rob_arf.sv
module rob_arf
    import rob_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  reg_t  rd_a,
    output data_t q_a,
    input  reg_t  rd_b,
    output data_t q_b,
    input  logic  we,
    input  reg_t  wa,
    input  data_t wd
);
    data_t regs [NUM_ARCH];
    assign q_a = regs[rd_a];
    assign q_b = regs[rd_b];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NUM_ARCH; r++) regs[r] <= '0;
        end else if (we) begin
            regs[wa] <= wd;
        end
    end
endmodule

// File: rtl/rob_window.sv
module rob_window
    import rob_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               alloc_valid,
    input  logic [OP_W-1:0]    alloc_op,
    input  logic [REG_W-1:0]   alloc_src_a,
    input  logic [REG_W-1:0]   alloc_src_b,
    input  logic               alloc_dst_en,
    input  logic [REG_W-1:0]   alloc_dst,
    output logic               alloc_stall,
    output logic [TAG_W-1:0]   alloc_tag,
    output logic               disp_valid,
    output logic [TAG_W-1:0]   disp_tag,
    output logic [OP_W-1:0]    disp_op,
    output logic [DATA_W-1:0]  disp_a,
    output logic [DATA_W-1:0]  disp_b,
    input  logic               done_valid,
    input  logic [TAG_W-1:0]   done_tag,
    input  logic [DATA_W-1:0]  done_data,
    input  logic               done_exc,
    input  logic [CAUSE_W-1:0] done_cause,
    output logic               cmt_valid,
    output logic [TAG_W-1:0]   cmt_tag,
    output logic               cmt_dst_en,
    output logic [REG_W-1:0]   cmt_dst,
    output logic [DATA_W-1:0]  cmt_data,
    output logic               flush,
    output logic [CAUSE_W-1:0] flush_cause
);
    slot_t win [ROB_DEPTH];
    ptr_t  head_q, tail_q;
    tag_t  head_i, tail_i;
    slot_t head_e;
    logic  retire_go, alloc_go, wake_go;

    assign head_i    = head_q[TAG_W-1:0];
    assign tail_i    = tail_q[TAG_W-1:0];
    assign head_e    = win[head_i];
    assign retire_go = head_e.used && head_e.done;
    assign flush     = retire_go && head_e.exc;
    assign cmt_valid = retire_go && !head_e.exc;
    assign cmt_tag   = head_i;
    assign cmt_dst_en  = head_e.dst_en;
    assign cmt_dst     = head_e.dst;
    assign cmt_data    = head_e.data;
    assign flush_cause = head_e.cause;

    assign alloc_stall = ptr_full(head_q, tail_q) || flush;
    assign alloc_tag   = tail_i;
    assign alloc_go    = alloc_valid && !alloc_stall;
    assign wake_go     = done_valid && !done_exc;

    // rename map and committed registers
    logic  ren_ha, ren_hb;
    tag_t  ren_ta, ren_tb;
    data_t arf_a, arf_b;

    rob_rename ren_i (
        .clk(clk), .rst(rst),
        .look_a(alloc_src_a), .look_b(alloc_src_b),
        .hit_a(ren_ha), .tag_a(ren_ta), .hit_b(ren_hb), .tag_b(ren_tb),
        .set_en(alloc_go && alloc_dst_en), .set_reg(alloc_dst), .set_tag(tail_i),
        .rel_en(cmt_valid && head_e.dst_en), .rel_reg(head_e.dst), .rel_tag(head_i),
        .inv_all(flush)
    );

    rob_arf arf_i (
        .clk(clk), .rst(rst),
        .rd_a(alloc_src_a), .q_a(arf_a), .rd_b(alloc_src_b), .q_b(arf_b),
        .we(cmt_valid && head_e.dst_en), .wa(head_e.dst), .wd(head_e.data)
    );

    function automatic operand_t resolve(logic hit, tag_t t, data_t committed);
        operand_t o;
        if (!hit) begin
            o.p = 1'b1; o.v = committed;
        end else if (win[t].done) begin
            o.p = 1'b1; o.v = win[t].data;
        end else if (wake_go && done_tag == t) begin
            o.p = 1'b1; o.v = done_data;
        end else begin
            o.p = 1'b0; o.v = data_t'(t);
        end
        return o;
    endfunction

    operand_t new_a, new_b;
    assign new_a = resolve(ren_ha, ren_ta, arf_a);
    assign new_b = resolve(ren_hb, ren_tb, arf_b);

    // oldest-ready selection
    logic [ROB_DEPTH-1:0] rdy;
    tag_t                 pick_i;
    always_comb begin
        for (int i = 0; i < ROB_DEPTH; i++)
            rdy[i] = win[i].used && !win[i].exec && win[i].a.p && win[i].b.p;
    end

    rob_pick #(.N(ROB_DEPTH), .W(TAG_W)) pick_u (
        .rdy(rdy), .base(head_i), .hit(disp_valid), .idx(pick_i)
    );

    assign disp_tag = pick_i;
    assign disp_op  = win[pick_i].op;
    assign disp_a   = win[pick_i].a.v;
    assign disp_b   = win[pick_i].b.v;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ROB_DEPTH; i++) win[i] <= '0;
            head_q <= '0;
            tail_q <= '0;
        end else begin
            for (int i = 0; i < ROB_DEPTH; i++) begin
                if (wake_go && win[i].used) begin
                    if (!win[i].a.p && win[i].a.v[TAG_W-1:0] == done_tag) begin
                        win[i].a.p <= 1'b1;
                        win[i].a.v <= done_data;
                    end
                    if (!win[i].b.p && win[i].b.v[TAG_W-1:0] == done_tag) begin
                        win[i].b.p <= 1'b1;
                        win[i].b.v <= done_data;
                    end
                end
            end
            if (done_valid && win[done_tag].used) begin
                win[done_tag].done  <= 1'b1;
                win[done_tag].data  <= done_data;
                win[done_tag].exc   <= done_exc;
                win[done_tag].cause <= done_cause;
            end
            if (disp_valid) win[pick_i].exec <= 1'b1;
            if (alloc_go) begin
                win[tail_i] <= '{used: 1'b1, exec: 1'b0, done: 1'b0, op: alloc_op,
                                 a: new_a, b: new_b, dst_en: alloc_dst_en,
                                 dst: alloc_dst, data: '0, exc: 1'b0, cause: '0};
                tail_q <= tail_q + 1'b1;
            end
            if (cmt_valid) begin
                win[head_i].used <= 1'b0;
                head_q <= head_q + 1'b1;
            end
            if (flush) begin
                for (int i = 0; i < ROB_DEPTH; i++) win[i].used <= 1'b0;
                tail_q <= head_q;
            end
        end
    end
endmodule

// File: rtl/rob_window_chk.sv
module rob_window_chk
    import rob_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       alloc_valid,
    input logic       alloc_stall,
    input logic [TAG_W-1:0] alloc_tag,
    input logic       disp_valid,
    input logic [TAG_W-1:0] disp_tag,
    input logic       cmt_valid,
    input logic [TAG_W-1:0] cmt_tag,
    input logic       flush
);
    ptr_t exp_head, exp_tail, occ;
    assign occ = exp_tail - exp_head;

    always_ff @(posedge clk) begin
        if (rst) begin
            exp_head <= '0;
            exp_tail <= '0;
        end else begin
            if (alloc_valid && !alloc_stall) exp_tail <= exp_tail + 1'b1;
            if (cmt_valid) exp_head <= exp_head + 1'b1;
            if (flush) exp_tail <= exp_head;
        end
    end

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !disp_valid && !cmt_valid && !flush && !alloc_stall);
    // R2
    a_r2_tag_order: assert property (@(posedge clk) disable iff (rst)
        (alloc_valid && !alloc_stall) |-> alloc_tag == exp_tail[TAG_W-1:0]);
    a_r2_full_stall: assert property (@(posedge clk) disable iff (rst)
        (occ == ptr_t'(ROB_DEPTH)) |-> alloc_stall);
    // R5
    a_r5_no_redispatch: assert property (@(posedge clk) disable iff (rst)
        disp_valid |=> !(disp_valid && disp_tag == $past(disp_tag)));
    // R7
    a_r7_retire_order: assert property (@(posedge clk) disable iff (rst)
        (cmt_valid || flush) |-> cmt_tag == exp_head[TAG_W-1:0]);
    a_r7_empty_no_retire: assert property (@(posedge clk) disable iff (rst)
        (occ == '0) |-> !cmt_valid && !flush);
    // R8
    a_r8_flush_drains: assert property (@(posedge clk) disable iff (rst)
        flush |=> !flush && !disp_valid && !cmt_valid);
endmodule

bind rob_window rob_window_chk chk_i (
    .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_stall(alloc_stall),
    .alloc_tag(alloc_tag), .disp_valid(disp_valid), .disp_tag(disp_tag),
    .cmt_valid(cmt_valid), .cmt_tag(cmt_tag), .flush(flush)
);

// File: tb/rob_window_tb_top.sv
`timescale 1ns/1ps
module rob_window_tb_top;
    import rob_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic               alloc_valid = 1'b0;
    logic [OP_W-1:0]    alloc_op = '0;
    logic [REG_W-1:0]   alloc_src_a = '0, alloc_src_b = '0, alloc_dst = '0;
    logic               alloc_dst_en = 1'b0;
    logic               alloc_stall;
    logic [TAG_W-1:0]   alloc_tag;
    logic               disp_valid;
    logic [TAG_W-1:0]   disp_tag;
    logic [OP_W-1:0]    disp_op;
    logic [DATA_W-1:0]  disp_a, disp_b;
    logic               done_valid = 1'b0, done_exc = 1'b0;
    logic [TAG_W-1:0]   done_tag = '0;
    logic [DATA_W-1:0]  done_data = '0;
    logic [CAUSE_W-1:0] done_cause = '0;
    logic               cmt_valid, cmt_dst_en, flush;
    logic [TAG_W-1:0]   cmt_tag;
    logic [REG_W-1:0]   cmt_dst;
    logic [DATA_W-1:0]  cmt_data;
    logic [CAUSE_W-1:0] flush_cause;

    rob_window dut_i (.*);

    typedef struct { int tag; int a; int b; string req; } dexp_t;
    typedef struct { bit fl; int tag; int dst; int data; int cause; string req; } cexp_t;
    dexp_t dq[$];
    cexp_t cq[$];

    int  checks = 0, failures = 0;
    bit  running = 1'b0, finished = 1'b0;

    task automatic check(bit ok, string req, string act, string exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%s expected=%s", req, act, exp);
        end
    endtask

    task automatic push_d(int tag, int a, int b, string req);
        dq.push_back('{tag, a, b, req});
    endtask
    task automatic push_c(int tag, int dst, int data, string req);
        cq.push_back('{1'b0, tag, dst, data, 0, req});
    endtask
    task automatic push_f(int tag, int cause, string req);
        cq.push_back('{1'b1, tag, 0, 0, cause, req});
    endtask

    task automatic tick();
        @(posedge clk); #2;
        alloc_valid = 1'b0;
        done_valid  = 1'b0;
        done_exc    = 1'b0;
    endtask
    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask
    task automatic set_alloc(int op, int sa, int sb, int d);
        alloc_valid = 1'b1; alloc_op = OP_W'(op);
        alloc_src_a = REG_W'(sa); alloc_src_b = REG_W'(sb);
        alloc_dst_en = 1'b1; alloc_dst = REG_W'(d);
    endtask
    task automatic set_done(int tag, int data, bit exc = 1'b0, int cause = 0);
        done_valid = 1'b1; done_tag = TAG_W'(tag); done_data = DATA_W'(data);
        done_exc = exc; done_cause = CAUSE_W'(cause);
    endtask

    // monitor: compares dispatch and retirement against the expectation queues
    always @(negedge clk) begin
        if (running) begin
            if (disp_valid) begin
                if (dq.size() == 0) begin
                    check(1'b0, "R5", $sformatf("dispatch tag %0d", disp_tag), "no dispatch");
                end else begin
                    dexp_t d;
                    d = dq.pop_front();
                    check(int'(disp_tag) == d.tag && int'(disp_a) == d.a && int'(disp_b) == d.b,
                          d.req, $sformatf("t%0d a=%h b=%h", disp_tag, disp_a, disp_b),
                          $sformatf("t%0d a=%h b=%h", d.tag, d.a, d.b));
                end
            end
            if (cmt_valid || flush) begin
                if (cq.size() == 0) begin
                    check(1'b0, "R7", $sformatf("retire tag %0d", cmt_tag), "no retire");
                end else begin
                    cexp_t c;
                    c = cq.pop_front();
                    if (c.fl)
                        check(flush && !cmt_valid && int'(cmt_tag) == c.tag && int'(flush_cause) == c.cause,
                              c.req, $sformatf("flush=%0b t%0d cause=%0d", flush, cmt_tag, flush_cause),
                              $sformatf("flush=1 t%0d cause=%0d", c.tag, c.cause));
                    else
                        check(cmt_valid && cmt_dst_en && int'(cmt_tag) == c.tag &&
                              int'(cmt_dst) == c.dst && int'(cmt_data) == c.data,
                              c.req, $sformatf("v=%0b t%0d r%0d=%h", cmt_valid, cmt_tag, cmt_dst, cmt_data),
                              $sformatf("v=1 t%0d r%0d=%h", c.tag, c.dst, c.data));
                end
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        running = 1'b1;
        @(negedge clk);
        check(!disp_valid && !cmt_valid && !flush && !alloc_stall && alloc_tag == 0, "R1",
              $sformatf("d%0b c%0b f%0b s%0b t%0d", disp_valid, cmt_valid, flush, alloc_stall, alloc_tag),
              "all low, tag 0");

        // R3/R7: sources with no producer read committed zeros
        set_alloc(1, 0, 0, 1); push_d(0, 0, 0, "R3"); tick();
        set_alloc(1, 0, 0, 2); push_d(1, 0, 0, "R3"); tick();
        tick();
        set_done(0, 'h11); push_c(0, 1, 'h11, "R7"); tick();
        set_done(1, 'h22); push_c(1, 2, 'h22, "R7"); tick();
        idle(3);

        // R4: wakeup from broadcast
        set_alloc(2, 1, 2, 3); push_d(2, 'h11, 'h22, "R3"); tick();
        set_alloc(2, 3, 1, 4); push_d(3, 'h33, 'h11, "R4"); tick();
        tick();
        set_done(2, 'h33); push_c(2, 3, 'h33, "R7"); tick();
        idle(2);
        set_done(3, 'h44); push_c(3, 4, 'h44, "R7"); tick();
        idle(3);

        // R3: broadcast in the allocation cycle (tags wrapped, R2)
        set_alloc(3, 1, 1, 5); push_d(0, 'h11, 'h11, "R2"); tick();
        tick();
        set_alloc(3, 5, 2, 6); set_done(0, 'h55);
        push_c(0, 5, 'h55, "R7"); push_d(1, 'h55, 'h22, "R3"); tick();
        idle(2);
        set_done(1, 'h66); push_c(1, 6, 'h66, "R7"); tick();
        idle(3);

        // R6: two entries woken together, head at slot 2
        set_alloc(4, 1, 2, 7); push_d(2, 'h11, 'h22, "R3"); tick();
        set_alloc(4, 7, 2, 1); tick();
        set_alloc(4, 7, 3, 2); tick();
        set_alloc(4, 2, 6, 1); tick();
        @(negedge clk);
        check(alloc_stall == 1'b1, "R2", $sformatf("stall=%0b", alloc_stall), "stall=1");
        set_alloc(9, 0, 0, 3); tick();
        @(negedge clk);
        check(alloc_stall && alloc_tag == 2, "R2",
              $sformatf("stall=%0b tag=%0d", alloc_stall, alloc_tag), "stall=1 tag=2");
        set_done(2, 'h77); push_c(2, 7, 'h77, "R7");
        push_d(3, 'h77, 'h22, "R6"); push_d(0, 'h77, 'h33, "R6"); tick();
        idle(3);
        set_done(3, 'h88); push_c(3, 1, 'h88, "R7"); tick();
        set_done(0, 'h99); push_c(0, 2, 'h99, "R7"); push_d(1, 'h99, 'h66, "R4"); tick();
        idle(3);
        // R10: r1 still maps to slot 1 after slot 3 retired
        set_alloc(5, 1, 0, 4); push_d(2, 'hAA, 0, "R10"); tick();
        set_done(1, 'hAA); push_c(1, 1, 'hAA, "R7"); tick();
        // R3: producer finished but not yet retired
        set_alloc(5, 1, 4, 5); push_d(3, 'hAA, 'hBB, "R3"); tick();
        tick();
        set_done(2, 'hBB); push_c(2, 4, 'hBB, "R7"); tick();
        tick();
        set_done(3, 'hCC); push_c(3, 5, 'hCC, "R7"); tick();
        idle(3);

        // R8/R9: exception at the head
        set_alloc(6, 5, 5, 6); push_d(0, 'hCC, 'hCC, "R3"); tick();
        set_alloc(6, 6, 1, 7); tick();
        tick();
        set_done(0, 'hDEAD, 1'b1, 5); push_f(0, 5, "R8"); tick();
        @(negedge clk);
        check(flush && alloc_stall, "R8", $sformatf("flush=%0b stall=%0b", flush, alloc_stall), "both 1");
        tick();
        @(negedge clk);
        check(!disp_valid && !cmt_valid && !flush && !alloc_stall && alloc_tag == 0, "R8",
              $sformatf("d%0b c%0b f%0b s%0b t%0d", disp_valid, cmt_valid, flush, alloc_stall, alloc_tag),
              "empty, tag 0");
        set_alloc(7, 6, 7, 2); push_d(0, 'h66, 'h77, "R9"); tick();
        tick();
        set_done(0, 'h12); push_c(0, 2, 'h12, "R7"); tick();
        idle(4);

        check(dq.size() == 0, "R5", $sformatf("%0d pending dispatches", dq.size()), "0");
        check(cq.size() == 0, "R7", $sformatf("%0d pending retirements", cq.size()), "0");
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule